// File: doc/BRIEF.md
# Ordered Store Buffer with Fence Gating

This block sits between a processor's load/store port and a slow memory port. Stores are taken into a small in-order queue in one cycle, so the processor moves on while memory spends many cycles on each store. The queue sends its entries to memory oldest first. It issues one store at a time and waits for that store's acknowledge before issuing the next.

Loads may overtake queued stores to other addresses. A load whose address equals any queued store is held back until every such store has been acknowledged. Its data is never taken from the queue. Fence pulses of three kinds let software restore ordering: a full fence holds both loads and stores, a store fence holds stores, and a load fence holds loads. A strict-ordering input makes every access wait until the queue is empty.

Top module: `store_fence_buffer`

## Requirements
- R1: After synchronous reset the queue is empty, `cpu_wr_ready` is high, `mem_req_valid` is low and `fence_busy` is low.
- R2: A store offered while the queue has room and no hold applies is accepted in the same cycle (`cpu_wr_valid` and `cpu_wr_ready` both high).
- R3: While `DEPTH` stores are queued, `cpu_wr_ready` is low. It rises only after an entry retires.
- R4: Queued stores are presented to memory oldest first. A new store request is never presented while an earlier store is still awaiting `mem_wr_ack`.
- R5: A load whose address equals the address of any queued store is not sent to memory until all of those stores have been acknowledged. A store that is acknowledged in the same cycle as the compare no longer blocks the load. The data the load returns is that of the most recent store accepted before the load was sent.
- R6: A load whose address matches no queued store may be sent to memory ahead of older queued stores.
- R7: At most one load is outstanding. When a store and a load could both start a request in the same cycle, the store starts first.
- R8: A load completes in the cycle `mem_rd_ack` pulses. In that cycle `cpu_rd_done` is high and `cpu_rd_data` carries `mem_rd_data`.
- R9: A fence of kind 2'b00 or 2'b11 (full) holds loads and stores, starting the next cycle. The hold lasts until the queue is empty and no load is outstanding. `fence_busy` is high while any fence holds.
- R10: A fence of kind 2'b01 (store) holds stores, starting the next cycle, until the queue is empty. Loads are not affected.
- R11: A fence of kind 2'b10 (load) holds loads, starting the next cycle, until no load is outstanding. Stores are not affected.
- R12: While `strict_mode` is high, stores are accepted and loads are sent only when the queue is empty.
- R13: A memory request that is not accepted keeps `mem_req_valid`, `mem_req_write`, `mem_req_addr` and `mem_req_wdata` unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strict_mode | input | 1 | Makes every access wait for an empty queue |
| cpu_wr_valid | input | 1 | Processor offers a store |
| cpu_wr_ready | output | 1 | Store accepted this cycle when valid |
| cpu_wr_addr | input | ADDR_W | Store word address |
| cpu_wr_data | input | DATA_W | Store data |
| cpu_rd_valid | input | 1 | Processor load pending; held with its address until done |
| cpu_rd_addr | input | ADDR_W | Load word address |
| cpu_rd_done | output | 1 | Load completes this cycle |
| cpu_rd_data | output | DATA_W | Load data, valid with `cpu_rd_done` |
| cpu_fence_valid | input | 1 | One-cycle fence pulse |
| cpu_fence_kind | input | 2 | 00/11 full, 01 store, 10 load |
| fence_busy | output | 1 | Some fence is still holding accesses |
| mem_req_valid | output | 1 | Memory request presented |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_req_write | output | 1 | 1 for store, 0 for load |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | DATA_W | Store data, zero for loads |
| mem_wr_ack | input | 1 | One-cycle pulse: outstanding store done |
| mem_rd_ack | input | 1 | One-cycle pulse: outstanding load done |
| mem_rd_data | input | DATA_W | Load data with `mem_rd_ack` |

## Verification
The assertions assume that memory pulses `mem_wr_ack` only while a store it has taken is outstanding, and `mem_rd_ack` only while a load is outstanding. Each pulse lasts one cycle. They also assume the processor holds a load's valid and address until `cpu_rd_done`, and holds a store until it is accepted. The bench's memory agent starts an acknowledge timer only on an observed request handshake. Its processor agents release a request only on the matching handshake or completion, so random stimulus stays within those assumptions. Addresses are drawn from eight words so that loads often hit queued stores.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_REQ  = 2'd1,
        CH_WAIT = 2'd2
    } chan_state_t;

    typedef enum logic [1:0] {
        FN_FULL     = 2'b00,
        FN_STORE    = 2'b01,
        FN_LOAD     = 2'b10,
        FN_FULL_ALT = 2'b11
    } fence_kind_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wentry_t;

    function automatic logic fence_holds_store(fence_kind_t k);
        return k != FN_LOAD;
    endfunction

    function automatic logic fence_holds_load(fence_kind_t k);
        return k != FN_STORE;
    endfunction

    function automatic logic fence_is_full(fence_kind_t k);
        return (k == FN_FULL) || (k == FN_FULL_ALT);
    endfunction

    // request channel: idle -> presenting -> awaiting acknowledge -> idle
    function automatic chan_state_t chan_next(chan_state_t s, logic go,
                                              logic taken, logic ack);
        case (s)
            CH_IDLE: return go    ? CH_REQ  : CH_IDLE;
            CH_REQ:  return taken ? CH_WAIT : CH_REQ;
            CH_WAIT: return ack   ? CH_IDLE : CH_WAIT;
            default: return CH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/sfb_queue.sv
module sfb_queue
    import sfb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  wentry_t           push_ent,
    input  logic              pop,
    input  logic [ADDR_W-1:0] cmp_addr,
    output wentry_t           head_ent,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic              hit
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    wentry_t          slots [DEPTH];
    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] match;
    logic [PW-1:0]    head_ptr;
    logic [PW-1:0]    tail_ptr;

    function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // every slot compares in parallel; the slot retiring now is excluded
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = vld[i] && (slots[i].addr == cmp_addr)
                          && !(pop && (head_ptr == PW'(i)));
    end

    assign hit      = |match;
    assign head_ent = slots[head_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld      <= '0;
            head_ptr <= '0;
            tail_ptr <= '0;
            count    <= '0;
        end else begin
            if (push) begin
                slots[tail_ptr] <= push_ent;
                vld[tail_ptr]   <= 1'b1;
                tail_ptr        <= ptr_inc(tail_ptr);
            end
            if (pop) begin
                vld[head_ptr] <= 1'b0;
                head_ptr      <= ptr_inc(head_ptr);
            end
            count <= count + CW'(push) - CW'(pop);
        end
    end

endmodule

// File: rtl/sfb_fence.sv
module sfb_fence
    import sfb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fence_valid,
    input  logic [1:0] fence_kind,
    input  logic       buf_empty,
    input  logic       rd_idle,
    output logic       hold_wr,
    output logic       hold_rd,
    output logic       busy
);
    logic        pend_full, pend_store, pend_load;
    logic        set_full, set_store, set_load;
    fence_kind_t kind;

    assign kind      = fence_kind_t'(fence_kind);
    assign set_full  = fence_valid && fence_is_full(kind);
    assign set_store = fence_valid && fence_holds_store(kind) && !fence_is_full(kind);
    assign set_load  = fence_valid && fence_holds_load(kind) && !fence_is_full(kind);

    // a new fence wins over completion so it holds at least one cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_full  <= 1'b0;
            pend_store <= 1'b0;
            pend_load  <= 1'b0;
        end else begin
            pend_full  <= set_full  || (pend_full  && !(buf_empty && rd_idle));
            pend_store <= set_store || (pend_store && !buf_empty);
            pend_load  <= set_load  || (pend_load  && !rd_idle);
        end
    end

    assign hold_wr = pend_full || pend_store;
    assign hold_rd = pend_full || pend_load;
    assign busy    = pend_full || pend_store || pend_load;

endmodule

// File: rtl/sfb_port.sv
module sfb_port
    import sfb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              have_entry,
    input  wentry_t           head_ent,
    input  logic              rd_valid,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_clear,
    input  logic              mem_req_ready,
    input  logic              mem_wr_ack,
    input  logic              mem_rd_ack,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    output logic              retire,
    output logic              rd_idle,
    output logic              rd_done
);
    chan_state_t       wr_q, rd_q;
    logic              wr_go, rd_go;
    logic [ADDR_W-1:0] rd_addr_q;

    // drain wins when both channels could start together
    assign wr_go = have_entry && (wr_q == CH_IDLE) && (rd_q != CH_REQ);
    assign rd_go = rd_valid && (rd_q == CH_IDLE) && rd_clear
                   && !wr_go && (wr_q != CH_REQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q      <= CH_IDLE;
            rd_q      <= CH_IDLE;
            rd_addr_q <= '0;
        end else begin
            wr_q <= chan_next(wr_q, wr_go, mem_req_ready, mem_wr_ack);
            rd_q <= chan_next(rd_q, rd_go, mem_req_ready, mem_rd_ack);
            if (rd_go) rd_addr_q <= rd_addr;
        end
    end

    assign mem_req_write = (wr_q == CH_REQ);
    assign mem_req_valid = mem_req_write || (rd_q == CH_REQ);
    assign mem_req_addr  = mem_req_write ? head_ent.addr : rd_addr_q;
    assign mem_req_wdata = mem_req_write ? head_ent.data : '0;
    assign retire        = (wr_q == CH_WAIT) && mem_wr_ack;
    assign rd_idle       = (rd_q == CH_IDLE);
    assign rd_done       = (rd_q == CH_WAIT) && mem_rd_ack;

endmodule

// File: rtl/store_fence_buffer.sv
module store_fence_buffer
    import sfb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strict_mode,
    input  logic              cpu_wr_valid,
    output logic              cpu_wr_ready,
    input  logic [ADDR_W-1:0] cpu_wr_addr,
    input  logic [DATA_W-1:0] cpu_wr_data,
    input  logic              cpu_rd_valid,
    input  logic [ADDR_W-1:0] cpu_rd_addr,
    output logic              cpu_rd_done,
    output logic [DATA_W-1:0] cpu_rd_data,
    input  logic              cpu_fence_valid,
    input  logic [1:0]        cpu_fence_kind,
    output logic              fence_busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_wr_ack,
    input  logic              mem_rd_ack,
    input  logic [DATA_W-1:0] mem_rd_data
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] count;
    logic          empty, hit, retire, rd_idle;
    logic          hold_wr, hold_rd, push, rd_clear;
    wentry_t       head_ent, push_ent;

    assign empty        = (count == '0);
    assign cpu_wr_ready = (count < CW'(DEPTH)) && !hold_wr && !(strict_mode && !empty);
    assign push         = cpu_wr_valid && cpu_wr_ready;
    assign push_ent     = '{addr: cpu_wr_addr, data: cpu_wr_data};
    assign rd_clear     = !hit && !hold_rd && !(strict_mode && !empty);
    assign cpu_rd_data  = mem_rd_data;

    sfb_queue #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (push_ent),
        .pop      (retire),
        .cmp_addr (cpu_rd_addr),
        .head_ent (head_ent),
        .count    (count),
        .hit      (hit)
    );

    sfb_fence u_fence (
        .clk         (clk),
        .rst         (rst),
        .fence_valid (cpu_fence_valid),
        .fence_kind  (cpu_fence_kind),
        .buf_empty   (empty),
        .rd_idle     (rd_idle),
        .hold_wr     (hold_wr),
        .hold_rd     (hold_rd),
        .busy        (fence_busy)
    );

    sfb_port u_port (
        .clk           (clk),
        .rst           (rst),
        .have_entry    (!empty),
        .head_ent      (head_ent),
        .rd_valid      (cpu_rd_valid),
        .rd_addr       (cpu_rd_addr),
        .rd_clear      (rd_clear),
        .mem_req_ready (mem_req_ready),
        .mem_wr_ack    (mem_wr_ack),
        .mem_rd_ack    (mem_rd_ack),
        .mem_req_valid (mem_req_valid),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .retire        (retire),
        .rd_idle       (rd_idle),
        .rd_done       (cpu_rd_done)
    );

endmodule

// File: rtl/sfb_checker.sv
module sfb_checker
    import sfb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              strict_mode,
    input logic              cpu_wr_valid,
    input logic              cpu_wr_ready,
    input logic              cpu_rd_done,
    input logic              cpu_fence_valid,
    input logic [1:0]        cpu_fence_kind,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata,
    input logic              mem_wr_ack,
    input logic              mem_rd_ack
);
    logic [7:0] occ;
    logic       wr_out, rd_out;

    // shadow state rebuilt from port handshakes only
    always_ff @(posedge clk) begin
        if (rst) begin
            occ    <= '0;
            wr_out <= 1'b0;
            rd_out <= 1'b0;
        end else begin
            occ <= occ + 8'(cpu_wr_valid && cpu_wr_ready) - 8'(mem_wr_ack);
            if (mem_wr_ack) wr_out <= 1'b0;
            else if (mem_req_valid && mem_req_ready && mem_req_write) wr_out <= 1'b1;
            if (mem_rd_ack) rd_out <= 1'b0;
            else if (mem_req_valid && mem_req_ready && !mem_req_write) rd_out <= 1'b1;
        end
    end

    assert_occ_bound_R3: assert property (@(posedge clk) disable iff (rst)
        occ <= 8'(DEPTH));

    assert_full_blocks_R3: assert property (@(posedge clk) disable iff (rst)
        (occ == 8'(DEPTH)) |-> !cpu_wr_ready);

    assert_one_store_R4: assert property (@(posedge clk) disable iff (rst)
        wr_out |-> !(mem_req_valid && mem_req_write));

    assert_one_load_R7: assert property (@(posedge clk) disable iff (rst)
        rd_out |-> !(mem_req_valid && !mem_req_write));

    assert_done_needs_load_R8: assert property (@(posedge clk) disable iff (rst)
        cpu_rd_done |-> rd_out);

    assert_store_fence_R10: assert property (@(posedge clk) disable iff (rst)
        (cpu_fence_valid && (cpu_fence_kind != 2'b10)) |=> !cpu_wr_ready);

    assert_strict_store_R12: assert property (@(posedge clk) disable iff (rst)
        (strict_mode && (occ != '0)) |-> !cpu_wr_ready);

    assert_req_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_write)
            && $stable(mem_req_addr) && $stable(mem_req_wdata)));

endmodule

bind store_fence_buffer sfb_checker #(.DEPTH(DEPTH)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .strict_mode     (strict_mode),
    .cpu_wr_valid    (cpu_wr_valid),
    .cpu_wr_ready    (cpu_wr_ready),
    .cpu_rd_done     (cpu_rd_done),
    .cpu_fence_valid (cpu_fence_valid),
    .cpu_fence_kind  (cpu_fence_kind),
    .mem_req_valid   (mem_req_valid),
    .mem_req_ready   (mem_req_ready),
    .mem_req_write   (mem_req_write),
    .mem_req_addr    (mem_req_addr),
    .mem_req_wdata   (mem_req_wdata),
    .mem_wr_ack      (mem_wr_ack),
    .mem_rd_ack      (mem_rd_ack)
);

// File: tb/sim_store_fence_buffer.sv
module sim_store_fence_buffer;
    import sfb_pkg::*;

    localparam int DEPTH = 4;
    localparam int NCYC  = 4000;

    logic              clk = 1'b0;
    logic              rst;
    logic              strict_mode;
    logic              cpu_wr_valid, cpu_wr_ready;
    logic [ADDR_W-1:0] cpu_wr_addr;
    logic [DATA_W-1:0] cpu_wr_data;
    logic              cpu_rd_valid, cpu_rd_done;
    logic [ADDR_W-1:0] cpu_rd_addr;
    logic [DATA_W-1:0] cpu_rd_data;
    logic              cpu_fence_valid, fence_busy;
    logic [1:0]        cpu_fence_kind;
    logic              mem_req_valid, mem_req_ready, mem_req_write;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [DATA_W-1:0] mem_req_wdata;
    logic              mem_wr_ack, mem_rd_ack;
    logic [DATA_W-1:0] mem_rd_data;

    always #5 clk = ~clk;

    store_fence_buffer #(.DEPTH(DEPTH)) u0 (.*);

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    logic [ADDR_W-1:0] mq_addr[$];
    logic [DATA_W-1:0] mq_data[$];
    int                m_wr_st, m_rd_st;   // 0 idle, 1 presenting, 2 awaiting ack
    logic [ADDR_W-1:0] m_rd_addr;
    bit                m_f_full, m_f_st, m_f_ld;

    // agents
    logic [DATA_W-1:0] mem_arr  [8];
    logic [DATA_W-1:0] view_arr [8];
    logic [DATA_W-1:0] exp_rd, r_sample, w_pend_data;
    logic [2:0]        w_pend_addr;
    int                wtimer, rtimer;
    bit                w_act, r_act;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; strict_mode = 1'b0;
        cpu_wr_valid = 0; cpu_wr_addr = '0; cpu_wr_data = '0;
        cpu_rd_valid = 0; cpu_rd_addr = '0;
        cpu_fence_valid = 0; cpu_fence_kind = '0;
        mem_req_ready = 0; mem_wr_ack = 0; mem_rd_ack = 0; mem_rd_data = '0;
        for (int i = 0; i < 8; i++) begin mem_arr[i] = '0; view_arr[i] = '0; end
        m_wr_st = 0; m_rd_st = 0; m_rd_addr = '0;
        m_f_full = 0; m_f_st = 0; m_f_ld = 0;
        wtimer = 0; rtimer = 0; w_act = 0; r_act = 0; exp_rd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "wr_ready", 64'(cpu_wr_ready), 64'd1);
        chk("R1", "req_valid", 64'(mem_req_valid), 64'd0);
        chk("R1", "fence_busy", 64'(fence_busy), 64'd0);
        rst = 1'b0;

        for (int cyc = 0; cyc < NCYC; cyc++) begin
            int   cnt;
            bit   pop, hazard, wblk, rblk, wr_go, rd_go, e_ready, e_valid, e_write, e_done;
            bit   push, d_full, d_st, d_ld;
            logic [ADDR_W-1:0] e_addr;
            logic [DATA_W-1:0] e_wdata;
            @(negedge clk);
            // ---- drive stimulus
            strict_mode = (cyc >= 1500 && cyc < 2100);
            if (!w_act && ($urandom % 3 == 0)) begin
                w_act = 1; cpu_wr_addr = ADDR_W'($urandom % 8); cpu_wr_data = $urandom;
            end
            if (!r_act && ($urandom % 4 == 0)) begin
                r_act = 1; cpu_rd_addr = ADDR_W'($urandom % 8);
            end
            cpu_wr_valid    = w_act;
            cpu_rd_valid    = r_act;
            cpu_fence_valid = ($urandom % 20 == 0);
            cpu_fence_kind  = 2'($urandom % 4);
            mem_req_ready   = ($urandom % 4 != 0);
            mem_wr_ack      = (wtimer == 1);
            mem_rd_ack      = (rtimer == 1);
            mem_rd_data     = mem_rd_ack ? r_sample : '0;
            #1;
            // ---- model outputs for this cycle
            cnt  = mq_addr.size();
            pop  = (m_wr_st == 2) && mem_wr_ack;
            hazard = 0;
            // R5: any queued store to the load address blocks, except one retiring now
            for (int i = 0; i < cnt; i++)
                if (mq_addr[i] == cpu_rd_addr && !(pop && i == 0)) hazard = 1;
            // R9 R10 R11 R12: holds
            wblk = m_f_full || m_f_st || (strict_mode && cnt != 0);
            rblk = m_f_full || m_f_ld || (strict_mode && cnt != 0);
            e_ready = (cnt < DEPTH) && !wblk;            // R2 R3
            // R7: store start beats load start; R6: otherwise load may overtake
            wr_go = (cnt != 0) && (m_wr_st == 0) && (m_rd_st != 1);
            rd_go = cpu_rd_valid && (m_rd_st == 0) && !hazard && !rblk && !wr_go && (m_wr_st != 1);
            e_valid = (m_wr_st == 1) || (m_rd_st == 1);
            e_write = (m_wr_st == 1);
            e_addr  = e_write ? mq_addr[0] : m_rd_addr;
            e_wdata = e_write ? mq_data[0] : '0;
            e_done  = (m_rd_st == 2) && mem_rd_ack;   // R8

            chk("R2/R3", "wr_ready", 64'(cpu_wr_ready), 64'(e_ready));
            chk("R4/R7", "req_valid", 64'(mem_req_valid), 64'(e_valid));
            if (e_valid) begin
                chk("R4/R7", "req_write", 64'(mem_req_write), 64'(e_write));
                chk("R4/R13", "req_addr", 64'(mem_req_addr), 64'(e_addr));
                chk("R4/R13", "req_wdata", 64'(mem_req_wdata), 64'(e_wdata));
            end
            chk("R8", "rd_done", 64'(cpu_rd_done), 64'(e_done));
            chk("R9", "fence_busy", 64'(fence_busy), 64'(m_f_full || m_f_st || m_f_ld));
            if (e_done && cpu_rd_done) begin
                chk("R5/R6", "rd_data", 64'(cpu_rd_data), 64'(exp_rd));
                chk("R8", "rd_data_pass", 64'(cpu_rd_data), 64'(mem_rd_data));
            end

            // ---- model next state
            push = cpu_wr_valid && e_ready;
            if (rd_go) begin
                exp_rd    = view_arr[cpu_rd_addr[2:0]];
                m_rd_addr = cpu_rd_addr;
            end
            d_full = (cnt == 0) && (m_rd_st == 0);
            d_st   = (cnt == 0);
            d_ld   = (m_rd_st == 0);
            m_f_full = (cpu_fence_valid && (cpu_fence_kind == 2'b00 || cpu_fence_kind == 2'b11))
                       || (m_f_full && !d_full);
            m_f_st   = (cpu_fence_valid && cpu_fence_kind == 2'b01) || (m_f_st && !d_st);
            m_f_ld   = (cpu_fence_valid && cpu_fence_kind == 2'b10) || (m_f_ld && !d_ld);
            if (pop) begin void'(mq_addr.pop_front()); void'(mq_data.pop_front()); end
            if (push) begin mq_addr.push_back(cpu_wr_addr); mq_data.push_back(cpu_wr_data); end
            case (m_wr_st)
                0: if (wr_go) m_wr_st = 1;
                1: if (mem_req_ready) m_wr_st = 2;
                default: if (mem_wr_ack) m_wr_st = 0;
            endcase
            case (m_rd_st)
                0: if (rd_go) m_rd_st = 1;
                1: if (mem_req_ready) m_rd_st = 2;
                default: if (mem_rd_ack) m_rd_st = 0;
            endcase

            // ---- agents react to the design's actual ports
            if (cpu_wr_valid && cpu_wr_ready) begin
                view_arr[cpu_wr_addr[2:0]] = cpu_wr_data;
                w_act = 0;
            end
            if (cpu_rd_done) r_act = 0;
            if (mem_wr_ack) begin
                mem_arr[w_pend_addr] = w_pend_data; wtimer = 0;
            end else if (wtimer > 1) wtimer--;
            if (mem_rd_ack) rtimer = 0;
            else if (rtimer > 1) rtimer--;
            if (mem_req_valid && mem_req_ready && mem_req_write) begin
                w_pend_addr = mem_req_addr[2:0]; w_pend_data = mem_req_wdata;
                wtimer = 3 + int'($urandom % 10);
            end
            if (mem_req_valid && mem_req_ready && !mem_req_write) begin
                r_sample = mem_arr[mem_req_addr[2:0]];
                rtimer = 2 + int'($urandom % 8);
            end
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule